// File: doc/BRIEF.md
# Input transition capture counter

This block is one timer input channel. A pin is brought through a synchronizer and watched for the edge kind chosen by the host. Each counted edge records a capture word, which comes from one of two free-running timers or from a small register file read through a side port. The channel counts these edges against a programmable limit. When the count reaches the limit, the channel records a final capture, signals a terminal event and may pulse a link trigger. It then either halts or begins a new series.

The host programs the channel through a small word-wide register port. It writes a configuration word, a limit and, in register-capture mode, a source address. It then writes a start command that arms the channel and chooses the capture kind. Results are read back through the same port. The interrupt output is a single-cycle pulse, and a sticky done flag keeps a record of it.

Top module: `edge_capture_counter`

Register addresses (host_addr): 0 configuration, 1 start command (reads 0), 2 source address, 3 limit, 4 count (read-only), 5 final capture (read-only), 6 last capture (read-only), 7 status. Configuration bits: [2:0] edge kind, [3] timer choice, [5:4] run mode, [7] interrupt enable. Status bits: [0] done (sticky), [1] halted, [2] armed.

## Requirements
- R1: After reset, irq and link_trig are low and count, final capture, last capture and status all read 0. The channel ignores every edge until a start command is given.
- R2: The pin passes through two flops before edge detection, so a counted edge appears in the count two clock edges after the first flop samples it. Edge kind 000 counts nothing, 001 counts rising edges, 010 counts falling edges and 011 counts both.
- R3: The edge kind is latched when a start command is accepted. If the field's top bit is 1 at that moment, the previously latched edge kind is kept.
- R4: A write of 01 (timer capture) or 10 (register capture) to start-command bits [1:0] clears the count, arms the channel and releases a halt. A write of 00 or 11 changes nothing.
- R5: In timer-capture mode, configuration bit 3 chooses the source. A 0 selects timer1 and a 1 selects timer2, latched at start and sampled in the cycle the edge is detected.
- R6: In register-capture mode, src_addr carries the programmed source address, and the capture word is src_data sampled in the detection cycle.
- R7: Each counted edge adds one to the count and stores the capture word in the last-capture register.
- R8: When the incremented count is greater than or equal to the limit, the capture word goes to the final-capture register and a terminal event occurs. A limit of 0 or 1 makes the first counted edge terminal.
- R9: With run mode bit 0 set, a terminal event clears the count and counting goes on. With it clear, the count holds, the halted status bit sets, and all later edges are ignored until the next start command.
- R10: With run mode bit 1 set, link_trig pulses high for exactly one cycle with each terminal event. It stays low otherwise.
- R11: Each terminal event sets status bit 0. Writing 1 to status bit 0 clears it, and a set in the same cycle takes precedence. irq is a one-cycle pulse on the terminal event, emitted only while configuration bit 7 is 1.
- R12: A new limit written while a series is in progress is applied at the next counted edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_addr | input | 3 | Host register address |
| host_wdata | input | HW | Host write data |
| host_rdata | output | HW | Host read data for host_addr (combinational) |
| pin_in | input | 1 | Asynchronous channel pin |
| timer1 | input | DW | First free-running timebase |
| timer2 | input | DW | Second free-running timebase |
| src_addr | output | AW | Address of the register word to capture |
| src_data | input | DW | Register word returned for src_addr |
| irq | output | 1 | One-cycle interrupt pulse |
| link_trig | output | 1 | One-cycle link trigger pulse |

## Verification
The properties assume that the count changes only through counted edges and start commands, since the host cannot write it. They also assume that the run mode bits are not rewritten in the middle of a series. The stimulus changes the configuration only before a start command and holds each pin level for four cycles, which is longer than the synchronizer and edge stages. Timer values and src_data are changed only between edges, so each capture sees a stable word.

// File: rtl/ecc_pkg.sv
// Shared encodings for the edge capture counter: edge kinds, start
// commands, configuration word layout and host register addresses.
package ecc_pkg;

    typedef enum logic [2:0] {
        EDGE_NONE = 3'b000,
        EDGE_RISE = 3'b001,
        EDGE_FALL = 3'b010,
        EDGE_ANY  = 3'b011
    } edge_sel_e;

    typedef enum logic [1:0] {
        START_IDLE  = 2'b00,
        START_TIMER = 2'b01,
        START_REG   = 2'b10,
        START_RSVD  = 2'b11
    } start_cmd_e;

    // configuration word, bit 7 down to bit 0
    typedef struct packed {
        logic       irq_en;
        logic       spare;
        logic [1:0] run_mode;   // [1] link, [0] continual
        logic       tmr_sel;
        logic [2:0] edge_sel;
    } cfg_t;

    localparam int RA_W = 3;
    localparam logic [RA_W-1:0] RA_CFG    = 3'd0;
    localparam logic [RA_W-1:0] RA_START  = 3'd1;
    localparam logic [RA_W-1:0] RA_SRC    = 3'd2;
    localparam logic [RA_W-1:0] RA_LIMIT  = 3'd3;
    localparam logic [RA_W-1:0] RA_COUNT  = 3'd4;
    localparam logic [RA_W-1:0] RA_FINAL  = 3'd5;
    localparam logic [RA_W-1:0] RA_LAST   = 3'd6;
    localparam logic [RA_W-1:0] RA_STATUS = 3'd7;

endpackage

// File: rtl/ecc_pin_sync.sv
// Pin synchronizer and edge detector.
// Passes the asynchronous pin through STAGES flops, then compares the
// last stage with one more flop to flag rising and falling edges.
// Assumes each pin level lasts at least one clock to be seen.
module ecc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic rise,
    output logic fall
);
    localparam int TOP = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                // first flop samples the raw pin
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= pin_async;
                end
            end else begin : g_next
                // later flops shift the sampled level along
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    // remembers the previous synchronized level for edge comparison
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[TOP];
    end

    // edge flags for the current cycle
    always_comb begin
        rise = sync_q[TOP] & ~prev_q;
        fall = ~sync_q[TOP] & prev_q;
    end
endmodule

// File: rtl/ecc_host_regs.sv
// Host register block.
// Holds the configuration, source address and limit registers, decodes
// start commands and the done-clear write, and muxes readback data.
// Assumes DW, CW and AW do not exceed HW.
module ecc_host_regs
    import ecc_pkg::*;
#(
    parameter int HW = 16,
    parameter int DW = 16,
    parameter int CW = 16,
    parameter int AW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [RA_W-1:0] addr,
    input  logic [HW-1:0]   wdata,
    input  logic [CW-1:0]   count_q,
    input  logic [DW-1:0]   final_q,
    input  logic [DW-1:0]   last_q,
    input  logic            done_q,
    input  logic            halted_q,
    input  logic            armed_q,
    output cfg_t            cfg_q,
    output logic [AW-1:0]   src_addr_q,
    output logic [CW-1:0]   limit_q,
    output logic            start_go,
    output start_cmd_e      start_code,
    output logic            done_clr,
    output logic [HW-1:0]   rdata
);
    localparam int STAT_W = 3;

    logic [STAT_W-1:0] status_bits;

    // decodes write strobes into single-cycle command pulses
    always_comb begin
        start_code = start_cmd_e'(wdata[1:0]);
        start_go   = wr_en && (addr == RA_START) &&
                     ((start_code == START_TIMER) || (start_code == START_REG));
        done_clr   = wr_en && (addr == RA_STATUS) && wdata[0];
    end

    // stores host-writable configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q      <= '0;
            src_addr_q <= '0;
            limit_q    <= '0;
        end else if (wr_en) begin
            case (addr)
                RA_CFG: begin
                    cfg_q       <= cfg_t'(wdata[7:0]);
                    cfg_q.spare <= 1'b0;
                end
                RA_SRC:   src_addr_q <= wdata[AW-1:0];
                RA_LIMIT: limit_q    <= wdata[CW-1:0];
                default:  ;
            endcase
        end
    end

    // selects the word shown on the read port
    always_comb begin
        status_bits = {armed_q, halted_q, done_q};
        case (addr)
            RA_CFG:    rdata = HW'(cfg_q);
            RA_SRC:    rdata = HW'(src_addr_q);
            RA_LIMIT:  rdata = HW'(limit_q);
            RA_COUNT:  rdata = HW'(count_q);
            RA_FINAL:  rdata = HW'(final_q);
            RA_LAST:   rdata = HW'(last_q);
            RA_STATUS: rdata = HW'(status_bits);
            default:   rdata = '0;
        endcase
    end
endmodule

// File: rtl/ecc_count_core.sv
// Counting and capture core.
// Latches the edge kind and capture source at start, counts matching
// edges, records last and final captures and issues terminal pulses.
// Assumes run mode bits stay fixed during a series.
module ecc_count_core
    import ecc_pkg::*;
#(
    parameter int DW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rise,
    input  logic          fall,
    input  cfg_t          cfg_q,
    input  logic [CW-1:0] limit_q,
    input  logic          start_go,
    input  start_cmd_e    start_code,
    input  logic          done_clr,
    input  logic [DW-1:0] timer1,
    input  logic [DW-1:0] timer2,
    input  logic [DW-1:0] src_data,
    output logic [CW-1:0] count_q,
    output logic [DW-1:0] final_q,
    output logic [DW-1:0] last_q,
    output logic          armed_q,
    output logic          halted_q,
    output logic          done_q,
    output logic          term_q,
    output logic          link_q,
    output logic          hit
);
    edge_sel_e     esel_q;
    logic          tmr_q;
    logic          regmode_q;
    logic          edge_match;
    logic          at_limit;
    logic          fire;
    logic [CW:0]   next_cnt;
    logic [DW-1:0] cap_val;

    // matches the latched edge kind against detector flags
    always_comb begin
        case (esel_q)
            EDGE_RISE: edge_match = rise;
            EDGE_FALL: edge_match = fall;
            EDGE_ANY:  edge_match = rise | fall;
            default:   edge_match = 1'b0;
        endcase
    end

    // forms the counted-edge, limit compare and capture word
    always_comb begin
        hit      = armed_q & ~halted_q & ~start_go & edge_match;
        next_cnt = {1'b0, count_q} + 1'b1;
        at_limit = next_cnt >= {1'b0, limit_q};
        fire     = hit & at_limit;
        if (regmode_q)  cap_val = src_data;
        else if (tmr_q) cap_val = timer2;
        else            cap_val = timer1;
    end

    // latches edge kind and capture source on a start command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            esel_q    <= EDGE_NONE;
            tmr_q     <= 1'b0;
            regmode_q <= 1'b0;
        end else if (start_go) begin
            if (!cfg_q.edge_sel[2]) esel_q <= edge_sel_e'(cfg_q.edge_sel);
            tmr_q     <= cfg_q.tmr_sel;
            regmode_q <= (start_code == START_REG);
        end
    end

    // advances the count and the armed and halted state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q  <= '0;
            armed_q  <= 1'b0;
            halted_q <= 1'b0;
        end else if (start_go) begin
            count_q  <= '0;
            armed_q  <= 1'b1;
            halted_q <= 1'b0;
        end else if (fire) begin
            if (cfg_q.run_mode[0]) begin
                count_q <= '0;
            end else begin
                count_q  <= next_cnt[CW-1:0];
                halted_q <= 1'b1;
            end
        end else if (hit) begin
            count_q <= next_cnt[CW-1:0];
        end
    end

    // records the last and final capture words
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_q  <= '0;
            final_q <= '0;
        end else if (hit) begin
            last_q <= cap_val;
            if (at_limit) final_q <= cap_val;
        end
    end

    // issues one-cycle terminal and link pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            term_q <= 1'b0;
            link_q <= 1'b0;
        end else begin
            term_q <= fire;
            link_q <= fire & cfg_q.run_mode[1];
        end
    end

    // keeps the sticky done flag, set winning over clear
    always_ff @(posedge clk) begin
        if (!rst_n)        done_q <= 1'b0;
        else if (fire)     done_q <= 1'b1;
        else if (done_clr) done_q <= 1'b0;
    end
endmodule

// File: rtl/edge_capture_counter.sv
// Input transition capture counter, top level.
// Ties the pin synchronizer, host registers and counting core together
// and gates the interrupt pulse with the host enable bit.
// Assumes the host changes run mode only between series.
module edge_capture_counter
    import ecc_pkg::*;
#(
    parameter int HW          = 16,
    parameter int DW          = 16,
    parameter int CW          = 16,
    parameter int AW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            host_wr_en,
    input  logic [RA_W-1:0] host_addr,
    input  logic [HW-1:0]   host_wdata,
    output logic [HW-1:0]   host_rdata,
    input  logic            pin_in,
    input  logic [DW-1:0]   timer1,
    input  logic [DW-1:0]   timer2,
    output logic [AW-1:0]   src_addr,
    input  logic [DW-1:0]   src_data,
    output logic            irq,
    output logic            link_trig
);
    cfg_t          cfg_q;
    start_cmd_e    start_code;
    logic          start_go, done_clr;
    logic          rise, fall, hit;
    logic [CW-1:0] limit_q, count_q;
    logic [DW-1:0] final_q, last_q;
    logic          armed_q, halted_q, done_q, term_q, link_q;

    ecc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_async (pin_in),
        .rise      (rise),
        .fall      (fall)
    );

    ecc_host_regs #(.HW(HW), .DW(DW), .CW(CW), .AW(AW)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (host_wr_en),
        .addr       (host_addr),
        .wdata      (host_wdata),
        .count_q    (count_q),
        .final_q    (final_q),
        .last_q     (last_q),
        .done_q     (done_q),
        .halted_q   (halted_q),
        .armed_q    (armed_q),
        .cfg_q      (cfg_q),
        .src_addr_q (src_addr),
        .limit_q    (limit_q),
        .start_go   (start_go),
        .start_code (start_code),
        .done_clr   (done_clr),
        .rdata      (host_rdata)
    );

    ecc_count_core #(.DW(DW), .CW(CW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .rise       (rise),
        .fall       (fall),
        .cfg_q      (cfg_q),
        .limit_q    (limit_q),
        .start_go   (start_go),
        .start_code (start_code),
        .done_clr   (done_clr),
        .timer1     (timer1),
        .timer2     (timer2),
        .src_data   (src_data),
        .count_q    (count_q),
        .final_q    (final_q),
        .last_q     (last_q),
        .armed_q    (armed_q),
        .halted_q   (halted_q),
        .done_q     (done_q),
        .term_q     (term_q),
        .link_q     (link_q),
        .hit        (hit)
    );

    // drives the gated interrupt and the link pulse
    always_comb begin
        irq       = term_q & cfg_q.irq_en;
        link_trig = link_q;
    end
endmodule

// File: rtl/ecc_checker.sv
// Property checker for the edge capture counter, bound to the top.
// Assumes the count is changed only by counted edges and start commands.
module ecc_checker #(
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_go,
    input logic          hit,
    input logic          term_q,
    input logic          halted_q,
    input logic          done_q,
    input logic [CW-1:0] count_q,
    input logic          irq,
    input logic          link_trig
);
    // R4
    start_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_go |=> (count_q == '0));

    // R9
    halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (halted_q && !start_go) |=> $stable(count_q));

    // R9
    cont_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (term_q && !halted_q) |-> (count_q == '0));

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> ((count_q == $past(count_q) + 1'b1) || (count_q == '0)));

    // R2
    idle_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!hit && !start_go) |=> $stable(count_q));

    // R10
    link_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_trig |-> term_q);

    // R11
    irq_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (term_q && done_q));
endmodule

bind edge_capture_counter ecc_checker #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_go  (start_go),
    .hit       (hit),
    .term_q    (term_q),
    .halted_q  (halted_q),
    .done_q    (done_q),
    .count_q   (count_q),
    .irq       (irq),
    .link_trig (link_trig)
);

// File: tb/tb_edge_capture_counter.sv
module tb_edge_capture_counter;
    localparam int CLK_PERIOD = 10;
    localparam int HW = 16;
    localparam int DW = 16;
    localparam int AW = 8;
    localparam int VW = 31;

    // ops: 0 write, 1 pin level, 2 read check, 3 timers, 4 irq total,
    // 5 link total, 7 src_data, 8 src_addr check, 9 pin pulse
    function automatic logic [VW-1:0] mk(input int op, input int a, input int d, input int r);
        return {4'(op), 3'(a), 16'(d), 8'(r)};
    endfunction

    localparam int NV = 57;
    localparam logic [VW-1:0] VEC [NV] = '{
        // rising, timer1, single-shot, limit 3
        mk(0, 0, 16'h0081, 0), mk(0, 3, 3, 0), mk(0, 1, 1, 0),
        mk(3, 0, 16'h1111, 0), mk(1, 0, 1, 0),
        mk(2, 4, 1, 7),            // R7
        mk(2, 6, 16'h1111, 5),     // R5
        mk(1, 0, 0, 0),
        mk(2, 4, 1, 2),            // R2 falling ignored
        mk(3, 0, 16'h2222, 0), mk(1, 0, 1, 0),
        mk(2, 6, 16'h2222, 7),     // R7
        mk(2, 5, 0, 8),            // R8 not yet final
        mk(3, 0, 16'h3333, 0), mk(1, 0, 0, 0), mk(1, 0, 1, 0),
        mk(2, 5, 16'h3333, 8),     // R8
        mk(4, 0, 1, 11),           // R11
        mk(5, 0, 0, 10),           // R10
        mk(2, 7, 7, 9),            // R9 halted
        mk(9, 0, 0, 0),
        mk(2, 4, 3, 9),            // R9 held
        mk(4, 0, 1, 9),            // R9
        mk(0, 7, 1, 0),
        mk(2, 7, 6, 11),           // R11 cleared
        // falling, timer2, continual with link, limit 2
        mk(0, 0, 16'h00BA, 0), mk(0, 3, 2, 0), mk(0, 1, 1, 0),
        mk(3, 0, 16'h0100, 0), mk(1, 0, 0, 0),
        mk(2, 6, 16'hFEFF, 5),     // R5 timer2
        mk(2, 4, 1, 7),            // R7
        mk(3, 0, 16'h0200, 0), mk(9, 0, 1, 0),
        mk(2, 4, 0, 9),            // R9 wrap
        mk(2, 5, 16'hFDFF, 8),     // R8
        mk(4, 0, 2, 11),           // R11
        mk(5, 0, 1, 10),           // R10
        mk(9, 0, 1, 0), mk(9, 0, 1, 0),
        mk(5, 0, 2, 10),           // R10
        mk(0, 3, 5, 0), mk(9, 0, 1, 0), mk(9, 0, 1, 0),
        mk(2, 4, 2, 12),           // R12
        mk(0, 3, 3, 0), mk(9, 0, 1, 0),
        mk(2, 4, 0, 12),           // R12
        mk(4, 0, 4, 12),           // R12
        // irq disabled, limit 1
        mk(0, 0, 16'h003A, 0), mk(0, 3, 1, 0), mk(0, 1, 1, 0), mk(9, 0, 1, 0),
        mk(4, 0, 4, 11),           // R11 gated
        mk(5, 0, 4, 10),           // R10
        mk(2, 7, 5, 11),           // R11 sticky
        mk(2, 4, 0, 8)             // R8
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            host_wr_en = 1'b0;
    logic [2:0]      host_addr = '0;
    logic [HW-1:0]   host_wdata = '0;
    logic [HW-1:0]   host_rdata;
    logic            pin_in = 1'b0;
    logic [DW-1:0]   timer1 = '0;
    logic [DW-1:0]   timer2 = '0;
    logic [AW-1:0]   src_addr;
    logic [DW-1:0]   src_data = '0;
    logic            irq;
    logic            link_trig;

    int total = 0;
    int bad = 0;
    int irq_seen = 0;
    int link_seen = 0;
    bit done = 1'b0;

    edge_capture_counter dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr_en (host_wr_en),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .pin_in     (pin_in),
        .timer1     (timer1),
        .timer2     (timer2),
        .src_addr   (src_addr),
        .src_data   (src_data),
        .irq        (irq),
        .link_trig  (link_trig)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // pulse tallies, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n && irq)       irq_seen++;
        if (rst_n && link_trig) link_seen++;
    end

    task automatic check(input int req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        host_wr_en = 1'b1;
        host_addr  = 3'(a);
        host_wdata = 16'(d);
        @(negedge clk);
        host_wr_en = 1'b0;
    endtask

    task automatic rd_chk(input int a, input int exp, input int req);
        @(negedge clk);
        host_addr = 3'(a);
        #1;
        check(req, int'(host_rdata), exp);
    endtask

    task automatic set_pin(input logic v);
        @(negedge clk);
        pin_in = v;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        check(1, int'(irq), 0);
        check(1, int'(link_trig), 0);
        rd_chk(4, 0, 1);
        rd_chk(5, 0, 1);
        rd_chk(6, 0, 1);
        rd_chk(7, 0, 1);
        // R1 unarmed channel ignores edges
        wr(0, 16'h0083);
        set_pin(1'b1);
        set_pin(1'b0);
        rd_chk(4, 0, 1);

        for (int i = 0; i < NV; i++) begin
            logic [3:0]  op;
            logic [2:0]  a;
            logic [15:0] d;
            logic [7:0]  r;
            {op, a, d, r} = VEC[i];
            case (op)
                4'd0: wr(int'(a), int'(d));
                4'd1: set_pin(d[0]);
                4'd2: rd_chk(int'(a), int'(d), int'(r));
                4'd3: begin
                    @(negedge clk);
                    timer1 = d;
                    timer2 = ~d;
                end
                4'd4: begin @(negedge clk); check(int'(r), irq_seen, int'(d)); end
                4'd5: begin @(negedge clk); check(int'(r), link_seen, int'(d)); end
                4'd7: begin @(negedge clk); src_data = d; end
                4'd8: begin @(negedge clk); check(int'(r), int'(src_addr), int'(d)); end
                4'd9: begin set_pin(d[0]); set_pin(~d[0]); end
                default: ;
            endcase
        end

        // R6 register capture with R3 kept edge kind (falling)
        wr(0, 16'h0084);
        wr(2, 16'h0022);
        @(negedge clk);
        src_data = 16'hBEEF;
        wr(3, 0);
        wr(1, 2);
        check(6, int'(src_addr), 16'h0022);
        set_pin(1'b1);
        rd_chk(4, 0, 3);
        set_pin(1'b0);
        rd_chk(5, 16'hBEEF, 6);
        rd_chk(4, 1, 8);
        check(8, irq_seen, 5);
        // R4 reserved start code leaves the halt in place
        wr(1, 3);
        rd_chk(7, 7, 4);
        rd_chk(4, 1, 4);
        wr(1, 0);
        rd_chk(7, 7, 4);
        wr(1, 1);
        rd_chk(7, 5, 4);
        rd_chk(4, 0, 4);
        // R2 edge kind none
        wr(0, 16'h0080);
        wr(1, 1);
        set_pin(1'b1);
        set_pin(1'b0);
        rd_chk(4, 0, 2);
        check(2, irq_seen, 5);
        // R2 both edges, continual, limit 0: every edge is terminal
        wr(0, 16'h0093);
        wr(1, 1);
        set_pin(1'b1);
        set_pin(1'b0);
        check(2, irq_seen, 7);
        rd_chk(4, 0, 9);
        // R11 set wins over clear is not reachable here; clear then verify
        wr(7, 1);
        rd_chk(7, 4, 11);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule